// File: doc/BRIEF.md
# Pseudo-SRAM Control Front End

This block is a clocked model of the control side of a pseudo-static RAM. Each cycle it decodes the active-low chip enable, write enable, output enable, two byte-lane selects and an active-low sleep pin into one of seven operating modes. It steers a 16-bit data path through per-lane output enables and a small inferred word store. A five-bit configuration register picks the low-power flavour and the size of the retained region. A hidden-refresh timer issues ticks that never collide with a bus access.

The bus has no handshake and no back-pressure. A read is combinational from the current address. A write, a configuration load and any loss of data caused by a low-power mode take effect at the rising clock edge that ends the cycle. The host holds its pins steady for that cycle. Words never written since reset, and bytes lost to a low-power mode, read back as the marker 0xDEAD, lane by lane.

Top module: `psram_ctrl`

## Requirements
- R1: With ce_n=1 and sleep_n=1 the mode is standby (mode_o=0) and dq_oe=00. we_n, oe_n, addr and dq_in change nothing: a later read returns the earlier contents.
- R2: With ce_n=0, we_n=1, oe_n=0, at least one byte select low and sleep_n=1, the mode is read (mode_o=1). dq_out carries the stored word at addr, and dq_oe enables the selected lanes.
- R3: With ce_n=0, we_n=0, at least one byte select low and sleep_n=1, the mode is write (mode_o=2) whatever oe_n is. The selected lanes of dq_in are stored at addr at the clock edge.
- R4: While we_n=0, dq_oe is 00, even with oe_n=0.
- R5: lb_n controls bits 7:0 and dq_oe[0]; ub_n controls bits 15:8 and dq_oe[1]. A write with one lane selected leaves the other byte unchanged.
- R6: With ce_n=0 and sleep_n=1 but neither read nor write conditions met, the mode is no-operation (mode_o=3), dq_oe=00 and the store is untouched.
- R7: With ce_n=0, we_n=0 and sleep_n=0 the mode is configuration load (mode_o=6). The register takes addr[4:0] at the clock edge and dq_oe=00.
- R8: Reset sets the configuration to 5'b10000. Only a configuration load changes it.
- R9: With ce_n=1 and sleep_n=0 the block is in low power: configuration bit 4 at 0 gives deep power-down (mode_o=5), and at 1 gives partial retention (mode_o=4).
- R10: Each deep power-down cycle marks every byte lost. Lost or never-written bytes read as the matching byte of 0xDEAD until they are written again.
- R11: Each partial-retention cycle keeps only the region chosen by configuration bits 1:0 and marks the rest lost. 00 keeps all, 01 keeps the lower half (address MSB 0), 10 keeps the lower quarter, and 11 keeps nothing.
- R12: The refresh timer wraps every REF_PERIOD cycles outside deep power-down and then raises a pending request. refresh_tick is high only while a request is pending and the mode is not read, write, configuration load or deep power-down. The request stays pending through such cycles and clears on the edge after the tick. After reset, an idle block shows its first tick after REF_PERIOD edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower byte select, active low |
| ub_n | input | 1 | Upper byte select, active low |
| sleep_n | input | 1 | Sleep request, active low |
| addr | input | AW | Word address; bits 4:0 feed configuration load |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data |
| dq_oe | output | 2 | Per-lane output enable (bit 1 upper, bit 0 lower) |
| mode_o | output | 3 | Decoded mode code |
| refresh_tick | output | 1 | Hidden refresh event |

## Verification
The decoder is tried with each of its pin combinations. Several patterns differ in a single pin, so each precedence rule is isolated: write with oe_n low against read, standby with we_n low against write, and no-operation with either oe_n high or both byte selects high. One-lane writes and reads show whether the lanes are swapped or merged. Reads of addresses inside and outside the retained region, taken after full-array, half-array and deep power-down settings, separate the three loss rules. A long run of reads with a pending request shows whether a refresh tick is deferred or leaks onto the bus.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [2:0] {
    M_STBY  = 3'd0,
    M_READ  = 3'd1,
    M_WRITE = 3'd2,
    M_NOP   = 3'd3,
    M_PAR   = 3'd4,
    M_DPD   = 3'd5,
    M_CFG   = 3'd6
  } mode_e;

  localparam int CFG_W       = 5;
  localparam int CFG_SEL_BIT = 4;
  localparam logic [CFG_W-1:0] CFG_RESET = 5'b10000;
  localparam logic [15:0] LOST_WORD = 16'hDEAD;
endpackage

// File: rtl/psram_mode_dec.sv
module psram_mode_dec
  import psram_pkg::*;
(
  input  logic  ce_n,
  input  logic  we_n,
  input  logic  oe_n,
  input  logic  lb_n,
  input  logic  ub_n,
  input  logic  sleep_n,
  input  logic  lp_retain,
  output mode_e mode,
  output logic  busy
);
  logic any_lane;
  assign any_lane = ~lb_n | ~ub_n;

  always_comb begin
    if (sleep_n) begin
      if (ce_n)                     mode = M_STBY;
      else if (!we_n && any_lane)   mode = M_WRITE;
      else if (!oe_n && any_lane)   mode = M_READ;
      else                          mode = M_NOP;
    end else begin
      if (ce_n)                     mode = lp_retain ? M_PAR : M_DPD;
      else if (!we_n)               mode = M_CFG;
      else                          mode = M_NOP;
    end
  end

  assign busy = (mode == M_READ) | (mode == M_WRITE) | (mode == M_CFG);
endmodule

// File: rtl/psram_cfg_reg.sv
module psram_cfg_reg
  import psram_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] din,
  output logic [CFG_W-1:0] cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= CFG_RESET;
    else if (load) cfg_q <= din;
  end

  p_cfg_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cfg_q == $past(din));
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));
endmodule

// File: rtl/psram_refresh_timer.sv
module psram_refresh_timer #(
  parameter int REF_PERIOD = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic halt,
  output logic tick
);
  localparam int CW = (REF_PERIOD > 1) ? $clog2(REF_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(REF_PERIOD - 1);

  logic [CW-1:0] cnt;
  logic          pend;
  logic          wrap;

  assign wrap = !halt && (cnt == LAST);
  assign tick = pend && !busy && !halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (!halt) cnt <= wrap ? '0 : cnt + 1'b1;
      pend <= (pend & ~tick) | wrap;
    end
  end

  p_pend_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !tick) |=> pend);
  p_no_tick_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tick);
endmodule

// File: rtl/psram_array.sv
module psram_array
  import psram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    lane_we,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   din,
  input  logic          lose_all,
  input  logic          par_sweep,
  input  logic [1:0]    par_field,
  output logic [15:0]   rd_data
);
  localparam int DEPTH = 1 << AW;
  localparam int LANES = 2;

  logic [DEPTH-1:0] keep_w;

  genvar w;
  generate
    for (w = 0; w < DEPTH; w++) begin : g_keep
      localparam logic [AW-1:0] IDX = AW'(w);
      assign keep_w[w] = (par_field == 2'd0)
                       | ((par_field == 2'd1) && !IDX[AW-1])
                       | ((par_field == 2'd2) && (IDX[AW-1:AW-2] == 2'b00));
    end
  endgenerate

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [7:0]       mem [DEPTH];
      logic [DEPTH-1:0] vld;

      always_ff @(posedge clk) begin
        if (wr_en && lane_we[g]) mem[addr] <= din[8*g +: 8];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   vld <= '0;
        else if (lose_all)            vld <= '0;
        else if (par_sweep)           vld <= vld & keep_w;
        else if (wr_en && lane_we[g]) vld[addr] <= 1'b1;
      end

      assign rd_data[8*g +: 8] = vld[addr] ? mem[addr] : LOST_WORD[8*g +: 8];

      p_dpd_lost_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lose_all |=> (vld == '0));
      p_par_no_gain_r11: assert property (@(posedge clk) disable iff (!rst_n)
        par_sweep |=> ((vld & ~$past(vld)) == '0));
    end
  endgenerate
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int AW         = 6,
  parameter int REF_PERIOD = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          lb_n,
  input  logic          ub_n,
  input  logic          sleep_n,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq_in,
  output logic [15:0]   dq_out,
  output logic [1:0]    dq_oe,
  output logic [2:0]    mode_o,
  output logic          refresh_tick
);
  mode_e            mode;
  logic             busy;
  logic [CFG_W-1:0] cfg_q;
  logic [1:0]       lane_sel;

  assign lane_sel = {~ub_n, ~lb_n};

  psram_mode_dec u_dec (
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n),
    .sleep_n(sleep_n), .lp_retain(cfg_q[CFG_SEL_BIT]),
    .mode(mode), .busy(busy)
  );

  psram_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .load(mode == M_CFG),
    .din(addr[CFG_W-1:0]), .cfg_q(cfg_q)
  );

  psram_refresh_timer #(.REF_PERIOD(REF_PERIOD)) u_ref (
    .clk(clk), .rst_n(rst_n), .busy(busy), .halt(mode == M_DPD),
    .tick(refresh_tick)
  );

  psram_array #(.AW(AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_en(mode == M_WRITE), .lane_we(lane_sel),
    .addr(addr), .din(dq_in), .lose_all(mode == M_DPD),
    .par_sweep(mode == M_PAR), .par_field(cfg_q[1:0]), .rd_data(dq_out)
  );

  assign dq_oe  = (mode == M_READ) ? lane_sel : 2'b00;
  assign mode_o = mode;

  p_standby_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && sleep_n) |-> (dq_oe == 2'b00));
  p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (dq_oe == 2'b00));
  p_lane_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe & {ub_n, lb_n}) == 2'b00);
  p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |-> (dq_oe == 2'b00));
  p_tick_hidden_r12: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_tick |-> (mode_o != 3'd1 && mode_o != 3'd2 && mode_o != 3'd5 && mode_o != 3'd6));
endmodule

// File: tb/psram_ctrl_tb.sv
`timescale 1ns/1ps
module psram_ctrl_tb;
  localparam int AW = 6;
  localparam int RP = 16;
  localparam int NV = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n, we_n, oe_n, lb_n, ub_n, sleep_n;
  logic [AW-1:0] addr;
  logic [15:0] dq_in, dq_out;
  logic [1:0]  dq_oe;
  logic [2:0]  mode_o;
  logic        refresh_tick;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  psram_ctrl #(.AW(AW), .REF_PERIOD(RP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .lb_n(lb_n), .ub_n(ub_n), .sleep_n(sleep_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .mode_o(mode_o), .refresh_tick(refresh_tick)
  );

  // ctl {ce,we,oe,lb,ub,sleep} | addr | din | mode | oe | data
  localparam logic [5:0] RD  = 6'b010001, WR  = 6'b000001, WRL = 6'b001011;
  localparam logic [5:0] RDU = 6'b010101, SBW = 6'b100001, NP1 = 6'b011001;
  localparam logic [5:0] NP2 = 6'b010111, CFG = 6'b001110, LPW = 6'b111110;

  localparam logic [48:0] VEC [NV] = '{
    {RD,  6'd5,  16'h0000, 3'd1, 2'b11, 16'hDEAD}, // R10 never written
    {WR,  6'd5,  16'h1234, 3'd2, 2'b00, 16'h0000}, // R3 R4 oe_n low
    {RD,  6'd5,  16'h0000, 3'd1, 2'b11, 16'h1234}, // R2
    {LPW, 6'd0,  16'h0000, 3'd4, 2'b00, 16'h0000}, // R8 R9 default retain
    {RD,  6'd5,  16'h0000, 3'd1, 2'b11, 16'h1234}, // R11 full array kept
    {WRL, 6'd5,  16'h00AB, 3'd2, 2'b00, 16'h0000}, // R5 lower lane
    {RD,  6'd5,  16'h0000, 3'd1, 2'b11, 16'h12AB}, // R5
    {RDU, 6'd5,  16'h0000, 3'd1, 2'b10, 16'h12AB}, // R5 upper only
    {SBW, 6'd5,  16'hFFFF, 3'd0, 2'b00, 16'h0000}, // R1 standby we low
    {RD,  6'd5,  16'h0000, 3'd1, 2'b11, 16'h12AB}, // R1 unchanged
    {NP1, 6'd5,  16'hFFFF, 3'd3, 2'b00, 16'h0000}, // R6 oe high
    {NP2, 6'd5,  16'hFFFF, 3'd3, 2'b00, 16'h0000}, // R6 no lane
    {RD,  6'd5,  16'h0000, 3'd1, 2'b11, 16'h12AB}, // R6 unchanged
    {WR,  6'd40, 16'h5555, 3'd2, 2'b00, 16'h0000}, // R3 upper half
    {WR,  6'd3,  16'h3333, 3'd2, 2'b00, 16'h0000}, // R3 lower half
    {CFG, 6'd17, 16'h0000, 3'd6, 2'b00, 16'h0000}, // R7 retain, lower half
    {LPW, 6'd0,  16'h0000, 3'd4, 2'b00, 16'h0000}, // R9
    {RD,  6'd40, 16'h0000, 3'd1, 2'b11, 16'hDEAD}, // R11 dropped
    {RD,  6'd3,  16'h0000, 3'd1, 2'b11, 16'h3333}, // R11 kept
    {CFG, 6'd0,  16'h0000, 3'd6, 2'b00, 16'h0000}, // R7 select power-down
    {LPW, 6'd0,  16'h0000, 3'd5, 2'b00, 16'h0000}, // R9 deep
    {RD,  6'd3,  16'h0000, 3'd1, 2'b11, 16'hDEAD}, // R10 lost
    {WR,  6'd3,  16'h7777, 3'd2, 2'b00, 16'h0000}, // R10 rewrite
    {RD,  6'd3,  16'h0000, 3'd1, 2'b11, 16'h7777}, // R10
    {RD,  6'd5,  16'h0000, 3'd1, 2'b11, 16'hDEAD}  // R10 lost
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] c, input logic [AW-1:0] a, input logic [15:0] d);
    {ce_n, we_n, oe_n, lb_n, ub_n, sleep_n} = c;
    addr = a;
    dq_in = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drive(6'b111111, '0, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    drive(6'b111111, '0, '0);
    do_reset();
    #1;
    check(mode_o == 3'd0, "R1 reset mode", 32'(mode_o), 0);
    check(dq_oe == 2'b00, "R1 reset oe", 32'(dq_oe), 0);
    check(refresh_tick == 1'b0, "R12 reset tick", 32'(refresh_tick), 0);

    // R12 first tick after RP edges while idle
    n = 0;
    while (n < 4 * RP) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (refresh_tick) break;
    end
    check(n == RP, "R12 first tick", 32'(n), 32'(RP));

    // R12 deferred while reads run
    for (int i = 0; i < 20; i++) begin
      drive(RD, 6'd1, '0);
      #1;
      check(refresh_tick == 1'b0, "R12 busy defers", 32'(refresh_tick), 0);
      @(negedge clk);
    end
    drive(6'b111111, '0, '0);
    #1;
    check(refresh_tick == 1'b1, "R12 deferred tick", 32'(refresh_tick), 1);
    @(negedge clk);
    check(refresh_tick == 1'b0, "R12 tick cleared", 32'(refresh_tick), 0);

    do_reset();
    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      logic [15:0] msk;
      v = VEC[i];
      drive(v[48:43], v[42:37], v[36:21]);
      #1;
      msk = {{8{v[17]}}, {8{v[16]}}};
      check(mode_o == v[20:18], $sformatf("R2 R9 row %0d mode", i), 32'(mode_o), 32'(v[20:18]));
      check(dq_oe == v[17:16], $sformatf("R4 R5 row %0d oe", i), 32'(dq_oe), 32'(v[17:16]));
      check(((dq_out ^ v[15:0]) & msk) == 16'h0, $sformatf("R2 R10 R11 row %0d data", i),
            32'(dq_out & msk), 32'(v[15:0] & msk));
      @(negedge clk);
    end

    drive(6'b111111, '0, '0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule